// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register and Mode Resolver

This block holds the basic control word of an Ethernet PHY's management register space and works out the configuration the link actually runs with. It combines the stored control bits with three strap pins and with the speed and duplex that auto-negotiation reports. The strap pins are: a hardware/software select, a negotiation select and a rate select. The combined result drives the effective speed, duplex, negotiation enable, loopback enable and collision-detection enable. A status bit gives the speed of the link that is currently up.

Management access uses a plain address/data port in place of the serial management frame layer. A write to the control address updates the implemented bits. A read returns the stored word one cycle after the request, along with a valid flag. A small latch captures the negotiated speed and duplex whenever a result strobe arrives while no link is active. With negotiation on, the effective speed and duplex come from this captured pair.

Top module: `phy_ctl_resolver`

## Requirements
- R1: After reset the control word reads 0x1000: only bit 12, negotiation enable, is set. The captured negotiation result is 10 Mb/s half duplex. In software mode the outputs then show negotiation on, loopback off and collision detection on.
- R2: A write with `wr_en` high and `addr` equal to 0 stores bits 14, 13, 12, 8 and 7 of `wr_data`. All other bits read as 0. Writes to other addresses change nothing. A read requested with `rd_en` returns data on `rd_data` in the next cycle with `rd_valid` high, and a read of any address other than 0 returns 0.
- R3: With `strap_sw` low (hardware mode), `eff_an_en` equals `pin_an_sel` and bit 12 has no effect.
- R4: In hardware mode, `eff_speed` equals `pin_rate_sel` (1 = 100 Mb/s, 0 = 10 Mb/s) and bit 13 has no effect.
- R5: With `strap_sw` high (software mode), `eff_an_en` equals bit 12.
- R6: In software mode with negotiation enabled, the effective speed and duplex are the captured negotiation result, and bits 13 and 8 have no effect.
- R7: In software mode with negotiation disabled, bit 13 gives the speed (1 = 100 Mb/s) and bit 8 gives the duplex (1 = full).
- R8: In any mode, the effective duplex is the captured result when negotiation is enabled and bit 8 otherwise.
- R9: The negotiated speed and duplex are captured on a clock edge only when `neg_valid` is high and `link_up` is low. A strobe while the link is up is ignored.
- R10: `rate_status` equals `eff_speed` while `link_up` is high and is 0 otherwise.
- R11: `eff_loopback` equals bit 14. `coll_det_en` is high when loopback is off or when bit 7 is set.
- R12: In hardware mode, a read returns the last written values of bits 13 and 12 even though those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sw | input | 1 | 1 = register bits rule, 0 = strap pins rule |
| pin_an_sel | input | 1 | Negotiation enable strap (hardware mode) |
| pin_rate_sel | input | 1 | Speed strap, 1 = 100 Mb/s (hardware mode) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read request |
| addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |
| rd_valid | output | 1 | Read data valid |
| neg_valid | input | 1 | Negotiation result strobe |
| neg_speed | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| neg_duplex | input | 1 | Negotiated duplex, 1 = full |
| link_up | input | 1 | Link active |
| eff_speed | output | 1 | Effective speed, 1 = 100 Mb/s |
| eff_duplex | output | 1 | Effective duplex, 1 = full |
| eff_an_en | output | 1 | Effective negotiation enable |
| eff_loopback | output | 1 | Loopback enable |
| coll_det_en | output | 1 | Collision detection enable |
| rate_status | output | 1 | Speed of the active link, 0 with no link |

## Verification
The bench writes bits 13 and 8 while negotiation is on and checks that the outputs do not move. A design that ignored the priority would switch to the manual speed there. It sends a negotiation strobe while the link is up; a latch that ignored `link_up` would change the speed of a running link. In hardware mode it writes bits 13 and 12 and checks that the outputs stay with the pins, then reads the bits back, which catches designs that drop or gate those writes. It also covers loopback with and without the collision override, and writes to a foreign address, which a loose address decode would accept.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int unsigned BIT_LOOP  = 14;
  localparam int unsigned BIT_RATE  = 13;
  localparam int unsigned BIT_ANEN  = 12;
  localparam int unsigned BIT_DUPX  = 8;
  localparam int unsigned BIT_COLF  = 7;

  typedef struct packed {
    logic loopback;
    logic rate;
    logic an_en;
    logic duplex;
    logic coll_force;
  } ctl_bits_t;

  typedef struct packed {
    logic speed;
    logic duplex;
  } neg_res_t;
endpackage

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output ctl_bits_t         bits
);
  localparam logic [DATA_W-1:0] WR_MASK =
      (DATA_W'(1) << BIT_LOOP) | (DATA_W'(1) << BIT_RATE) |
      (DATA_W'(1) << BIT_ANEN) | (DATA_W'(1) << BIT_DUPX) |
      (DATA_W'(1) << BIT_COLF);
  localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(1) << BIT_ANEN;
  localparam logic [ADDR_W-1:0] SEL     = ADDR_W'(CTRL_ADDR);

  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              rval_q;
  logic              hit;

  always_comb begin
    hit    = (addr == SEL);
    ctl_d  = ctl_q;
    if (wr_en && hit) ctl_d = wr_data & WR_MASK;
    rdat_d = hit ? ctl_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= RST_VAL;
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      rval_q <= rd_en;
      if (rd_en) rdat_q <= rdat_d;
    end
  end

  assign rd_data  = rdat_q;
  assign rd_valid = rval_q;
  assign bits = '{loopback:   ctl_q[BIT_LOOP],
                  rate:       ctl_q[BIT_RATE],
                  an_en:      ctl_q[BIT_ANEN],
                  duplex:     ctl_q[BIT_DUPX],
                  coll_force: ctl_q[BIT_COLF]};
endmodule

// File: rtl/phy_neg_latch.sv
module phy_neg_latch
  import phy_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     neg_valid,
  input  logic     neg_speed,
  input  logic     neg_duplex,
  input  logic     link_up,
  output neg_res_t res
);
  neg_res_t res_q, res_d;
  logic     cap_en;

  always_comb begin
    cap_en = neg_valid && !link_up;
    res_d  = '{speed: neg_speed, duplex: neg_duplex};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (cap_en) res_q <= res_d;
  end

  assign res = res_q;
endmodule

// File: rtl/phy_mode_resolve.sv
module phy_mode_resolve
  import phy_ctl_pkg::*;
(
  input  logic      strap_sw,
  input  logic      pin_an_sel,
  input  logic      pin_rate_sel,
  input  logic      link_up,
  input  ctl_bits_t bits,
  input  neg_res_t  neg,
  output logic      eff_speed,
  output logic      eff_duplex,
  output logic      eff_an_en,
  output logic      eff_loopback,
  output logic      coll_det_en,
  output logic      rate_status
);
  always_comb begin
    // strap selects owner of the negotiation enable
    eff_an_en = strap_sw ? bits.an_en : pin_an_sel;
    // speed priority: rate pin, then negotiation, then manual bit
    if (!strap_sw)      eff_speed = pin_rate_sel;
    else if (eff_an_en) eff_speed = neg.speed;
    else                eff_speed = bits.rate;
    eff_duplex   = eff_an_en ? neg.duplex : bits.duplex;
    eff_loopback = bits.loopback;
    coll_det_en  = !bits.loopback || bits.coll_force;
    rate_status  = link_up && eff_speed;
  end
endmodule

// File: rtl/phy_ctl_resolver.sv
module phy_ctl_resolver
  import phy_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_sw,
  input  logic              pin_an_sel,
  input  logic              pin_rate_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              neg_valid,
  input  logic              neg_speed,
  input  logic              neg_duplex,
  input  logic              link_up,
  output logic              eff_speed,
  output logic              eff_duplex,
  output logic              eff_an_en,
  output logic              eff_loopback,
  output logic              coll_det_en,
  output logic              rate_status
);
  logic [SYNC_LEN-1:0] rs_q;
  logic                rst_int_n;
  ctl_bits_t           bits;
  neg_res_t            neg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rs_q[SYNC_LEN-1];

  phy_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .bits(bits)
  );

  phy_neg_latch u_neg (
    .clk(clk), .rst_n(rst_int_n), .neg_valid(neg_valid), .neg_speed(neg_speed),
    .neg_duplex(neg_duplex), .link_up(link_up), .res(neg)
  );

  phy_mode_resolve u_res (
    .strap_sw(strap_sw), .pin_an_sel(pin_an_sel), .pin_rate_sel(pin_rate_sel),
    .link_up(link_up), .bits(bits), .neg(neg), .eff_speed(eff_speed),
    .eff_duplex(eff_duplex), .eff_an_en(eff_an_en), .eff_loopback(eff_loopback),
    .coll_det_en(coll_det_en), .rate_status(rate_status)
  );
endmodule

// File: rtl/phy_ctl_resolver_chk.sv
module phy_ctl_resolver_chk #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_sw,
  input logic              pin_an_sel,
  input logic              pin_rate_sel,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic              link_up,
  input logic              eff_speed,
  input logic              eff_duplex,
  input logic              eff_an_en,
  input logic              eff_loopback,
  input logic              coll_det_en,
  input logic              rate_status
);
  // R3
  hw_an_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_sw |-> eff_an_en == pin_an_sel);
  // R4
  hw_speed_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_sw |-> eff_speed == pin_rate_sel);
  // R11
  coll_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_loopback |-> coll_det_en);
  // R11
  loop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(CTRL_ADDR)) |=> eff_loopback == $past(wr_data[14]));
  // R10
  rate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> !rate_status);
  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R9
  neg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(link_up) && strap_sw && $past(strap_sw) && eff_an_en && $past(eff_an_en))
    |-> ($stable(eff_speed) && $stable(eff_duplex)));
endmodule

bind phy_ctl_resolver phy_ctl_resolver_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_sw(strap_sw), .pin_an_sel(pin_an_sel),
  .pin_rate_sel(pin_rate_sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_valid(rd_valid), .link_up(link_up), .eff_speed(eff_speed),
  .eff_duplex(eff_duplex), .eff_an_en(eff_an_en), .eff_loopback(eff_loopback),
  .coll_det_en(coll_det_en), .rate_status(rate_status)
);

// File: tb/sim_phy_ctl_resolver.sv
module sim_phy_ctl_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_sw, pin_an_sel, pin_rate_sel;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [15:0] wr_data, rd_data;
  logic        rd_valid;
  logic        neg_valid, neg_speed, neg_duplex, link_up;
  logic        eff_speed, eff_duplex, eff_an_en, eff_loopback, coll_det_en, rate_status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          is_rd;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;  // 250 MHz

  phy_ctl_resolver u0 (
    .clk(clk), .rst_n(rst_n), .strap_sw(strap_sw), .pin_an_sel(pin_an_sel),
    .pin_rate_sel(pin_rate_sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .neg_valid(neg_valid), .neg_speed(neg_speed), .neg_duplex(neg_duplex),
    .link_up(link_up), .eff_speed(eff_speed), .eff_duplex(eff_duplex),
    .eff_an_en(eff_an_en), .eff_loopback(eff_loopback),
    .coll_det_en(coll_det_en), .rate_status(rate_status)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin : monitor
    item_t       it;
    logic [15:0] act;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      if (it.is_rd)
        act = rd_valid ? rd_data : 16'hxxxx;
      else
        act = {10'd0, eff_speed, eff_duplex, eff_an_en, eff_loopback,
               coll_det_en, rate_status};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  // driver tasks
  task automatic expect_out(input logic [5:0] e, input string req);
    item_t it;
    it.is_rd = 1'b0; it.exp = {10'd0, e}; it.req = req;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string req);
    item_t it;
    @(posedge clk); #1;
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    it.is_rd = 1'b1; it.exp = e; it.req = req;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic neg_pulse(input logic s, input logic d);
    @(posedge clk); #1;
    neg_valid = 1'b1; neg_speed = s; neg_duplex = d;
    @(posedge clk); #1;
    neg_valid = 1'b0;
  endtask

  task automatic set_pins(input logic sw, input logic an, input logic rt, input logic lk);
    @(posedge clk); #1;
    strap_sw = sw; pin_an_sel = an; pin_rate_sel = rt; link_up = lk;
  endtask

  // output vector: {speed, duplex, an_en, loopback, coll_det, rate_status}
  initial begin : driver
    rst_n = 1'b0; strap_sw = 1'b1; pin_an_sel = 1'b0; pin_rate_sel = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    neg_valid = 1'b0; neg_speed = 1'b0; neg_duplex = 1'b0; link_up = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    rd(5'd0, 16'h1000, "R1 reset word");
    expect_out(6'b001010, "R1 reset outputs");

    wr(5'd0, 16'h3100);
    expect_out(6'b001010, "R6 bits 13/8 ignored with negotiation on");
    neg_pulse(1'b1, 1'b1);
    expect_out(6'b111010, "R9 capture while link down");
    set_pins(1'b1, 1'b0, 1'b0, 1'b1);
    expect_out(6'b111011, "R10 rate status with link up");
    neg_pulse(1'b0, 1'b0);
    expect_out(6'b111011, "R9 strobe ignored with link up");

    wr(5'd0, 16'h0000);
    expect_out(6'b000010, "R5 R7 manual 10 half");
    wr(5'd0, 16'h2100);
    expect_out(6'b110011, "R7 manual 100 full");
    wr(5'd0, 16'h2000);
    expect_out(6'b100011, "R7 manual 100 half");

    wr(5'd0, 16'h6000);
    expect_out(6'b100101, "R11 loopback, collision off");
    wr(5'd0, 16'h6080);
    expect_out(6'b100111, "R11 loopback with collision override");
    wr(5'd3, 16'h0000);
    expect_out(6'b100111, "R2 foreign address write ignored");
    rd(5'd0, 16'h6080, "R2 readback");
    rd(5'd3, 16'h0000, "R2 foreign address reads zero");
    wr(5'd0, 16'hFFFF);
    rd(5'd0, 16'h7180, "R2 unimplemented bits read zero");
    expect_out(6'b111111, "R6 R8 negotiation result drives outputs");

    set_pins(1'b0, 1'b0, 1'b0, 1'b1);
    expect_out(6'b010110, "R3 R4 R8 hardware mode pins rule");
    wr(5'd0, 16'h0000);
    expect_out(6'b000010, "R8 hardware duplex from bit 8");
    set_pins(1'b0, 1'b0, 1'b1, 1'b1);
    expect_out(6'b100011, "R4 rate pin high");
    set_pins(1'b0, 1'b1, 1'b1, 1'b1);
    expect_out(6'b111011, "R3 negotiation pin high");
    wr(5'd0, 16'h3000);
    expect_out(6'b111011, "R3 R4 bits 13/12 no effect in hardware mode");
    set_pins(1'b0, 1'b1, 1'b0, 1'b1);
    expect_out(6'b011010, "R4 rate pin low");
    rd(5'd0, 16'h3000, "R12 hardware mode readback");
    set_pins(1'b0, 1'b1, 1'b0, 1'b0);
    set_pins(1'b0, 1'b1, 1'b1, 1'b0);
    expect_out(6'b111010, "R10 no link gives zero rate status");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule